// File: doc/BRIEF.md
# Paged Effective Address Unit

This block resolves the operand address of a memory-reference instruction on a machine whose words and instructions are 12 bits wide and which has a single accumulator. A sequencer hands it the fetched instruction and the program counter of that instruction. The unit then forms a 7-bit word offset either within page 0 or within the 128-word page that holds the instruction. If the instruction asks for one level of indirection, the unit reads the pointer word through a simple synchronous memory port and uses that word's full 12 bits as the address.

Eight dedicated page-0 words act as auto-index pointers. An indirect reference through one of them first increments the stored pointer. The incremented value is written back to memory and is also the resulting address. I/O and operate-group instructions do not address memory. The unit reports them with the memory-reference flag low, and it makes no memory access for them.

The unit accepts one request at a time. It holds busy while it works and pulses done for one cycle when the address is valid. Operand fetch and execution belong to the surrounding datapath.

Top module: `ea_unit`

## Requirements
- R1: While reset is high and in the cycle after it falls, busy, done, mem_re and mem_we are all low.
- R2: The opcode is instr[11:9]. Values 0 to 5 are memory references. For values 6 and 7, done rises in the first cycle after acceptance with is_mem = 0 and ea = 0, and no memory read or write takes place.
- R3: The offset is instr[6:0]. When the page bit instr[7] is 0, the page-formed address is {5'b0, offset}. When it is 1, that address is {pc[11:7], offset}.
- R4: When the indirect bit instr[8] is 0, ea equals the page-formed address and is_mem = 1. done comes in the second cycle after acceptance, and no memory access takes place.
- R5: When instr[8] is 1 and the page-formed address lies outside 0o010 to 0o017, the unit makes exactly one read of that address and no write. ea equals the word read, and done comes in the third cycle after acceptance. Read data is valid in the cycle after mem_re, and mem_re and mem_we are never high together.
- R6: When instr[8] is 1 and the page-formed address lies in 0o010 to 0o017, the unit reads that word. In the next cycle it writes the word plus one back to the same address, and ea equals that incremented value. done comes in the third cycle after acceptance. The window applies to the formed address, so it is also reached with the page bit set while the PC is in page 0.
- R7: The auto-index increment wraps modulo 4096, so a pointer holding 0o7777 becomes 0.
- R8: A direct reference (instr[8] = 0) to an auto-index location leaves the stored word unchanged.
- R9: A request is accepted only at a clock edge where req_valid is high and busy is low. busy is high from the cycle after acceptance through the done cycle. A request presented while busy is high has no effect.
- R10: done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_instr | input | 12 | Fetched instruction word |
| req_pc | input | 12 | Address of that instruction |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle strobe; ea and is_mem valid |
| is_mem | output | 1 | Instruction is a memory reference |
| ea | output | 12 | Effective address (0 for non-memory opcodes) |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, one cycle after mem_re |

## Verification
The bench sweeps all 4096 instruction words, each with a different program counter, against its own memory model. This covers both page selections, direct and indirect forms and the two non-memory opcodes. A design that took the page from the wrong PC bits would give wrong addresses. One that applied auto-increment to direct references, or tested the offset instead of the formed address, would leave the wrong write count or the wrong memory contents. Directed cases cover a pointer holding 0o7777, which must become 0 and not carry into a 13th bit. They also cover page-1 access to the window while the PC is in page 0, and a request held high while busy, which a design that re-latched its inputs would answer with the wrong address.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int WORD_W      = 12;
    localparam int OPC_W       = 3;
    localparam int OFF_W       = 7;
    localparam int PAGE_W      = WORD_W - OFF_W;
    localparam int MEMREF_LAST = 5;

    typedef logic [WORD_W-1:0] word_t;

    // Instruction fields, most significant first
    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic             ind;
        logic             pg;
        logic [OFF_W-1:0] off;
    } instr_t;

    // Decoded request carried from acceptance to completion
    typedef struct packed {
        logic  is_mem;
        logic  ind;
        logic  auto_hit;
        word_t page_addr;
    } req_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIRECT,
        S_READ_PTR,
        S_WRITE_PTR,
        S_DONE
    } state_t;

    function automatic logic opc_is_memref(input logic [OPC_W-1:0] opc);
        return (opc <= OPC_W'(MEMREF_LAST));
    endfunction

    function automatic word_t page_address(input instr_t f, input word_t pc);
        word_t a;
        if (f.pg)
            a = {pc[WORD_W-1:OFF_W], f.off};
        else
            a = {{PAGE_W{1'b0}}, f.off};
        return a;
    endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
#(
    parameter int AUTO_BASE = 8,
    parameter int AUTO_NUM  = 8
) (
    input  word_t instr_w,
    input  word_t pc_w,
    output req_t  req
);

    localparam int    AW      = (AUTO_NUM > 1) ? $clog2(AUTO_NUM) : 0;
    localparam bit    ALIGNED = ((1 << AW) == AUTO_NUM) && ((AUTO_BASE % AUTO_NUM) == 0);
    localparam word_t WIN_LO  = word_t'(AUTO_BASE);
    localparam word_t WIN_HI  = word_t'(AUTO_BASE + AUTO_NUM - 1);

    instr_t f;
    word_t  pa;
    logic   memref;
    logic   in_win;

    assign f      = instr_t'(instr_w);
    assign memref = opc_is_memref(f.opc);
    assign pa     = page_address(f, pc_w);

    // Aligned power-of-two window: compare upper bits only
    generate
        if (ALIGNED) begin : g_mask
            assign in_win = (pa[WORD_W-1:AW] == WIN_LO[WORD_W-1:AW]);
        end else begin : g_range
            assign in_win = (pa >= WIN_LO) && (pa <= WIN_HI);
        end
    endgenerate

    assign req.is_mem    = memref;
    assign req.ind       = memref & f.ind;
    assign req.auto_hit  = memref & f.ind & in_win;
    assign req.page_addr = memref ? pa : '0;

endmodule

// File: rtl/ea_incr.sv
module ea_incr #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    logic [W-1:0] c;

    assign c[0] = 1'b1;

    // Ripple increment; carry out of the top bit is dropped (modulo 2^W)
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign y[i] = a[i] ^ c[i];
            if (i < W - 1) begin : g_carry
                assign c[i+1] = a[i] & c[i];
            end
        end
    endgenerate

endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   new_is_mem,
    input  logic   new_ind,
    input  logic   held_auto,
    output state_t state,
    output logic   busy,
    output logic   done,
    output logic   mem_re,
    output logic   mem_we
);

    state_t nxt;

    always_ff @(posedge clk) begin
        if (rst)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE: begin
                if (start) begin
                    if (!new_is_mem)
                        nxt = S_DONE;
                    else if (new_ind)
                        nxt = S_READ_PTR;
                    else
                        nxt = S_DIRECT;
                end
            end
            S_READ_PTR:  nxt = held_auto ? S_WRITE_PTR : S_DIRECT;
            S_DIRECT:    nxt = S_DONE;
            S_WRITE_PTR: nxt = S_DONE;
            S_DONE:      nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    assign busy   = (state != S_IDLE);
    assign done   = (state == S_DONE);
    assign mem_re = (state == S_READ_PTR);
    assign mem_we = (state == S_WRITE_PTR);

    // R10: strobe lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: a pointer read is followed by resolve or write-back
    a_r5_read_then_use: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (mem_we || state == S_DIRECT));

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AUTO_BASE = 8,
    parameter int AUTO_NUM  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_instr,
    input  logic [WORD_W-1:0] req_pc,
    output logic              busy,
    output logic              done,
    output logic              is_mem,
    output logic [WORD_W-1:0] ea,
    output logic              mem_re,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);

    req_t   dec;
    req_t   req_q;
    state_t state;
    word_t  ea_q;
    word_t  inc_val;
    logic   start;

    ea_decode #(
        .AUTO_BASE (AUTO_BASE),
        .AUTO_NUM  (AUTO_NUM)
    ) u_decode (
        .instr_w (req_instr),
        .pc_w    (req_pc),
        .req     (dec)
    );

    ea_incr #(
        .W (WORD_W)
    ) u_incr (
        .a (mem_rdata),
        .y (inc_val)
    );

    assign start = req_valid && (state == S_IDLE);

    ea_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .new_is_mem (dec.is_mem),
        .new_ind    (dec.ind),
        .held_auto  (req_q.auto_hit),
        .state      (state),
        .busy       (busy),
        .done       (done),
        .mem_re     (mem_re),
        .mem_we     (mem_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            ea_q  <= '0;
        end else begin
            if (start) begin
                req_q <= dec;
                ea_q  <= '0;
            end
            case (state)
                S_DIRECT:    ea_q <= req_q.ind ? mem_rdata : req_q.page_addr;
                S_WRITE_PTR: ea_q <= inc_val;
                default:     ;
            endcase
        end
    end

    assign is_mem    = req_q.is_mem;
    assign ea        = ea_q;
    assign mem_addr  = req_q.page_addr;
    assign mem_wdata = inc_val;

    // R9: an idle unit takes the request and turns busy
    a_r9_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R2: non-memory opcodes report a zero address
    a_r2_nomem_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !is_mem) |-> (ea == '0));

    // R6: write-back only right after the pointer read
    a_r6_wb_after_read: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(mem_re));

    // R6: write-back goes to the location just read
    a_r6_wb_same_addr: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == $past(mem_addr)));

    // R5: read and write never overlap
    a_r5_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    // R7: all-ones pointer wraps to zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_rdata == '1) |-> (mem_wdata == '0));

endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [11:0] req_instr;
    logic [11:0] req_pc;
    logic        busy, done, is_mem, mem_re, mem_we;
    logic [11:0] ea, mem_addr, mem_wdata;
    logic [11:0] mem_rdata;

    logic [11:0] mem [0:4095];
    int          wr_cnt;
    int          rd_cnt;
    int          n_chk;
    int          n_fail;
    bit          finished;

    always #10 clk = ~clk;

    ea_unit dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_instr (req_instr),
        .req_pc    (req_pc),
        .busy      (busy),
        .done      (done),
        .is_mem    (is_mem),
        .ea        (ea),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Issue one request and check it against values computed here
    task automatic do_req(input logic [11:0] ins, input logic [11:0] pc);
        logic [11:0] pa;
        logic [11:0] exp_ea;
        logic        exp_mem;
        int          exp_lat;
        int          exp_wr;
        int          exp_rd;
        int          lat;
        int          w0;
        int          r0;
        string       tag;
        logic [11:0] old_word;

        pa = ins[7] ? {pc[11:7], ins[6:0]} : {5'b0, ins[6:0]};
        old_word = mem[pa];
        if (ins[11:9] >= 3'd6) begin
            exp_mem = 0; exp_ea = 0; exp_lat = 1; exp_wr = 0; exp_rd = 0; tag = "R2";
        end else if (!ins[8]) begin
            exp_mem = 1; exp_ea = pa; exp_lat = 2; exp_wr = 0; exp_rd = 0; tag = "R3/R4/R8";
        end else if (pa >= 12'o010 && pa <= 12'o017) begin
            exp_mem = 1; exp_ea = old_word + 12'd1; exp_lat = 3; exp_wr = 1; exp_rd = 1;
            tag = "R3/R6/R7";
        end else begin
            exp_mem = 1; exp_ea = old_word; exp_lat = 3; exp_wr = 0; exp_rd = 1; tag = "R3/R5";
        end

        w0 = wr_cnt;
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_instr = ins;
        req_pc    = pc;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9", "busy after accept", busy, 1);
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, tag, "done latency", lat, exp_lat);
        check(is_mem == exp_mem, tag, "is_mem", is_mem, exp_mem);
        check(ea == exp_ea, tag, "ea", ea, exp_ea);
        @(negedge clk);
        check(done == 1'b0, "R10", "done after strobe", done, 0);
        check((wr_cnt - w0) == exp_wr, tag, "write count", wr_cnt - w0, exp_wr);
        check((rd_cnt - r0) == exp_rd, tag, "read count", rd_cnt - r0, exp_rd);
        if (exp_wr == 1)
            check(mem[pa] == exp_ea, tag, "pointer written back", mem[pa], exp_ea);
        else
            check(mem[pa] == old_word, tag, "word unchanged", mem[pa], old_word);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [11:0] held_ea;
        n_chk = 0;
        n_fail = 0;
        finished = 0;
        wr_cnt = 0;
        rd_cnt = 0;
        mem_rdata = '0;
        for (int a = 0; a < 4096; a++)
            mem[a] = 12'((a * 37 + 5) % 4096);
        rst = 1'b1;
        req_valid = 1'b0;
        req_instr = '0;
        req_pc = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_re && !mem_we, "R1", "outputs in reset",
              {busy, done, mem_re, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_re && !mem_we, "R1", "outputs after reset",
              {busy, done, mem_re, mem_we}, 0);

        // R7: pointer at all ones wraps to zero (opcode 1, indirect, page 0, offset 0o012)
        mem[12'o012] = 12'o7777;
        do_req({3'd1, 1'b1, 1'b0, 7'o012}, 12'o4321);

        // R6: window reached through current page while PC is in page 0
        mem[12'o010] = 12'o0777;
        do_req({3'd2, 1'b1, 1'b1, 7'o010}, 12'o0005);

        // R8: direct reference to a window word leaves it alone
        do_req({3'd3, 1'b0, 1'b0, 7'o011}, 12'o1200);

        // R5: indirect outside the window, current page
        do_req({3'd4, 1'b1, 1'b1, 7'o020}, 12'o7600);

        // R9: request held high while busy, with a different word shown
        @(negedge clk);
        req_valid = 1'b1;
        req_instr = {3'd0, 1'b0, 1'b1, 7'o055};
        req_pc    = 12'o3200;
        @(negedge clk);
        req_instr = {3'd5, 1'b0, 1'b0, 7'o001};
        req_pc    = 12'o0000;
        while (!done) @(negedge clk);
        held_ea = ea;
        req_valid = 1'b0;
        check(held_ea == 12'o3255, "R9", "ea with request held while busy", held_ea, 12'o3255);
        @(negedge clk);
        check(busy == 1'b0, "R9", "idle after held request", busy, 0);

        // Sweep every instruction word with a varying PC
        for (int i = 0; i < 4096; i++)
            do_req(12'(i), 12'((i * 613 + 341) % 4096));

        finish_run();
    end

endmodule